// File: doc/BRIEF.md
# Eight-Channel Byte-Mover DMA Controller

This controller copies bytes between a wide memory bus, addressed by a 16-bit offset plus an 8-bit bank, and an 8-bit peripheral bus. Software fills in one 16-byte register window per channel. That window holds the control byte, the peripheral base, the memory offset and bank, and a 16-bit byte count. Software then writes a channel bitmask to the start port. The engine serves the armed channels one at a time, lowest index first. For every byte it reads from the source side, writes to the destination side and updates that channel's memory offset and count.

Every phase takes a whole number of steps of `STEP` clock cycles. There is one step between the start write and the first phase, one step of overhead for the whole run, one step per channel and one step per byte. Some pairings of peripheral and memory address are forbidden. For those, the read is replaced by the open-bus value and the write is dropped. The open-bus value is the last byte written through the register port or moved by the engine.

Top module: `dma8_engine`

## Requirements
- R1: The register address is {channel[2:0], offset[3:0]}. The offset map is: 0 control, 1 peripheral base, 2/3 memory offset low/high, 4 memory bank, 5/6 count low/high, 7 spare bank, 8/9 spare word low/high, 0xA spare counter, 0xB and 0xF one shared spare byte. Every field reads back as written. A byte write leaves the other half of its 16-bit field unchanged. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R2: Offsets 0xC, 0xD and 0xE ignore writes and read as the open-bus byte. The open-bus byte is the last byte written through the register port or moved by the engine, and it is 0x00 after reset.
- R3: A start write with a nonzero mask raises `busy` in the next cycle. A zero mask does nothing. A start write while `busy` is high is ignored. Channels run one after another in ascending index order.
- R4: `busy` stays high for exactly STEP*(2 + Σ(1 + n_i)) cycles, where n_i is the byte count of each armed channel.
- R5: The peripheral address of byte k is the base plus an offset chosen by mode (control bits[2:0]) and k mod 4. Modes 1 and 5 use 0,1,0,1. Modes 3 and 7 use 0,0,1,1. Mode 4 uses 0,1,2,3. Modes 0, 2 and 6 use 0 for every byte.
- R6: After each byte the memory offset holds if control bit 3 is set. Otherwise it steps by -1 when bit 4 is set and by +1 when bit 4 is clear, wrapping in 16 bits. The bank never changes.
- R7: The count drops by one per byte, and the channel ends when it reaches zero, so a finished channel reads count 0. A starting count of 0 moves 65536 bytes.
- R8: Control bit 7 set means peripheral to memory, and clear means memory to peripheral. The read and write of a byte never share a cycle.
- R9: A peripheral access at effective address 0x80 is forbidden when the bank is 0x7E or 0x7F. It is also forbidden when the bank is a low bank (below 0x40, or 0x80 to 0xBF) and the memory offset is below 0x2000.
- R10: A memory access in a low bank is forbidden at offsets 0x420B, 0x420C, 0x4300 to 0x437F and 0x2100 to 0x21FF.
- R11: A forbidden read issues no request and yields the open-bus byte. A forbidden write issues no request. No bus request is made while idle.
- R12: Both buses return read data in the cycle after the request cycle. Every request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | {channel, offset} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| start_wr | input | 1 | Start strobe |
| start_mask | input | 8 | Channels to arm |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory write when set |
| mem_addr | output | 24 | {bank, offset} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| per_req | output | 1 | Peripheral bus request |
| per_we | output | 1 | Peripheral write when set |
| per_addr | output | 8 | Peripheral address |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data |

## Verification
The bench goes after decrementing offsets that wrap through zero, the mode offset patterns, and every forbidden pairing in both directions. A wrong pairing rule would show up as an extra or missing bus request, or as a byte that is not the open-bus value. It measures `busy` against the step formula, so a missing or extra overhead step shows up as a cycle count off by STEP. A start pulse in the middle of a run catches a design that re-arms while busy. A count of zero must still be running with count 0xFFFE after two bytes, which a design that treats zero as empty would fail.

// File: rtl/dma8_pkg.sv
package dma8_pkg;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_ALL, S_CHN, S_BYTE} dma8_state_t;

  // peripheral offset for byte index (mod 4) under a transfer mode
  function automatic logic [1:0] per_step(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: per_step = {1'b0, idx[0]};
      3'd3, 3'd7: per_step = {1'b0, idx[1]};
      3'd4:       per_step = idx;
      default:    per_step = 2'd0;
    endcase
  endfunction

  function automatic logic low_bank(input logic [7:0] bank);
    low_bank = (bank < 8'h40) || ((bank >= 8'h80) && (bank < 8'hC0));
  endfunction

  function automatic logic per_ok(input logic [7:0] pa, input logic [7:0] bank,
                                  input logic [15:0] ma);
    per_ok = !((pa == 8'h80) &&
               ((bank == 8'h7E) || (bank == 8'h7F) || (low_bank(bank) && (ma < 16'h2000))));
  endfunction

  function automatic logic mem_ok(input logic [7:0] bank, input logic [15:0] ma);
    mem_ok = !(low_bank(bank) &&
               ((ma == 16'h420B) || (ma == 16'h420C) ||
                ((ma >= 16'h4300) && (ma < 16'h4380)) ||
                ((ma >= 16'h2100) && (ma < 16'h2200))));
  endfunction

endpackage

// File: rtl/dma8_regfile.sv
module dma8_regfile #(
  parameter int CH_NUM = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [CH_W-1:0] acc_ch,
  input  logic [3:0]      acc_off,
  input  logic [7:0]      wdata,
  input  logic [7:0]      ob,
  output logic [7:0]      rdata,
  input  logic            upd_en,
  input  logic [CH_W-1:0] upd_ch,
  input  logic [15:0]     upd_maddr,
  input  logic [15:0]     upd_count,
  input  logic [CH_W-1:0] sel_ch,
  output logic [2:0]      sel_mode,
  output logic            sel_fix,
  output logic            sel_dec,
  output logic            sel_dir,
  output logic [7:0]      sel_paddr,
  output logic [15:0]     sel_maddr,
  output logic [7:0]      sel_bank,
  output logic [15:0]     sel_count
);
  logic [7:0]  ctrl_r  [CH_NUM];
  logic [7:0]  paddr_r [CH_NUM];
  logic [15:0] maddr_r [CH_NUM];
  logic [7:0]  bank_r  [CH_NUM];
  logic [15:0] cnt_r   [CH_NUM];
  logic [7:0]  xbank_r [CH_NUM];
  logic [15:0] xword_r [CH_NUM];
  logic [7:0]  xcnt_r  [CH_NUM];
  logic [7:0]  spare_r [CH_NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH_NUM; i++) begin
        ctrl_r[i]  <= '0;
        paddr_r[i] <= '0;
        maddr_r[i] <= '0;
        bank_r[i]  <= '0;
        cnt_r[i]   <= '0;
        xbank_r[i] <= '0;
        xword_r[i] <= '0;
        xcnt_r[i]  <= '0;
        spare_r[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        case (acc_off)
          4'h0: ctrl_r[acc_ch]         <= wdata;
          4'h1: paddr_r[acc_ch]        <= wdata;
          4'h2: maddr_r[acc_ch][7:0]   <= wdata;
          4'h3: maddr_r[acc_ch][15:8]  <= wdata;
          4'h4: bank_r[acc_ch]         <= wdata;
          4'h5: cnt_r[acc_ch][7:0]     <= wdata;
          4'h6: cnt_r[acc_ch][15:8]    <= wdata;
          4'h7: xbank_r[acc_ch]        <= wdata;
          4'h8: xword_r[acc_ch][7:0]   <= wdata;
          4'h9: xword_r[acc_ch][15:8]  <= wdata;
          4'hA: xcnt_r[acc_ch]         <= wdata;
          4'hB, 4'hF: spare_r[acc_ch]  <= wdata;
          default: ;
        endcase
      end
      if (upd_en) begin
        maddr_r[upd_ch] <= upd_maddr;
        cnt_r[upd_ch]   <= upd_count;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (acc_off)
        4'h0: rdata <= ctrl_r[acc_ch];
        4'h1: rdata <= paddr_r[acc_ch];
        4'h2: rdata <= maddr_r[acc_ch][7:0];
        4'h3: rdata <= maddr_r[acc_ch][15:8];
        4'h4: rdata <= bank_r[acc_ch];
        4'h5: rdata <= cnt_r[acc_ch][7:0];
        4'h6: rdata <= cnt_r[acc_ch][15:8];
        4'h7: rdata <= xbank_r[acc_ch];
        4'h8: rdata <= xword_r[acc_ch][7:0];
        4'h9: rdata <= xword_r[acc_ch][15:8];
        4'hA: rdata <= xcnt_r[acc_ch];
        4'hB, 4'hF: rdata <= spare_r[acc_ch];
        default: rdata <= ob;
      endcase
    end
  end

  assign sel_mode  = ctrl_r[sel_ch][2:0];
  assign sel_fix   = ctrl_r[sel_ch][3];
  assign sel_dec   = ctrl_r[sel_ch][4];
  assign sel_dir   = ctrl_r[sel_ch][7];
  assign sel_paddr = paddr_r[sel_ch];
  assign sel_maddr = maddr_r[sel_ch];
  assign sel_bank  = bank_r[sel_ch];
  assign sel_count = cnt_r[sel_ch];
endmodule

// File: rtl/dma8_seq.sv
module dma8_seq
  import dma8_pkg::*;
#(
  parameter int CH_NUM = 8,
  parameter int CH_W   = 3,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic [CH_NUM-1:0] start_mask,
  input  logic [2:0]        mode,
  input  logic              fix,
  input  logic              dec,
  input  logic              dir,
  input  logic [7:0]        paddr,
  input  logic [15:0]       maddr,
  input  logic [7:0]        bank,
  input  logic [15:0]       count,
  input  logic [7:0]        ob,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        per_rdata,
  output logic [CH_W-1:0]   ch,
  output logic              busy,
  output logic              upd_en,
  output logic [15:0]       upd_maddr,
  output logic [15:0]       upd_count,
  output logic              obs_en,
  output logic [7:0]        obs_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              per_req,
  output logic              per_we,
  output logic [7:0]        per_addr,
  output logic [7:0]        per_wdata
);
  localparam int CW = $clog2(STEP);

  dma8_state_t       state;
  logic [CW-1:0]     cyc;
  logic [CH_NUM-1:0] act;
  logic [1:0]        idx;

  logic              last;
  logic [7:0]        per_a;
  logic              pok, mok, src_ok, dst_ok;
  logic [CH_NUM-1:0] pool;
  logic              nxt_any;
  logic [CH_W-1:0]   nxt_ch;

  assign last   = (cyc == CW'(STEP - 1));
  assign per_a  = paddr + {6'd0, per_step(mode, idx)};
  assign pok    = per_ok(per_a, bank, maddr);
  assign mok    = mem_ok(bank, maddr);
  assign src_ok = dir ? pok : mok;
  assign dst_ok = dir ? mok : pok;

  assign obs_en    = (state == S_BYTE) && (cyc == CW'(2));
  assign obs_data  = src_ok ? (dir ? per_rdata : mem_rdata) : ob;
  assign upd_en    = (state == S_BYTE) && (cyc == CW'(3));
  assign upd_maddr = fix ? maddr : (dec ? maddr - 16'd1 : maddr + 16'd1);
  assign upd_count = count - 16'd1;

  // lowest pending channel
  assign pool = (state == S_BYTE) ? (act & ~(CH_NUM'(1) << ch)) : act;
  assign nxt_any = |pool;
  always_comb begin
    nxt_ch = '0;
    for (int i = CH_NUM - 1; i >= 0; i--) begin
      if (pool[i]) nxt_ch = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cyc       <= '0;
      act       <= '0;
      ch        <= '0;
      idx       <= '0;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      per_req   <= 1'b0;
      per_we    <= 1'b0;
      per_addr  <= '0;
      per_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      per_req <= 1'b0;
      if (state != S_IDLE) cyc <= last ? '0 : cyc + 1'b1;
      case (state)
        S_IDLE: begin
          cyc <= '0;
          if (start_wr && (|start_mask)) begin
            act   <= start_mask;
            busy  <= 1'b1;
            state <= S_ARM;
          end
        end
        S_ARM: if (last) state <= S_ALL;
        S_ALL: begin
          if (last) begin
            if (nxt_any) begin
              ch    <= nxt_ch;
              state <= S_CHN;
            end else begin
              busy  <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        S_CHN: begin
          if (last) begin
            idx   <= '0;
            state <= S_BYTE;
          end
        end
        S_BYTE: begin
          if (cyc == CW'(0) && src_ok) begin
            if (dir) begin
              per_req  <= 1'b1;
              per_we   <= 1'b0;
              per_addr <= per_a;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= {bank, maddr};
            end
          end
          if (cyc == CW'(2) && dst_ok) begin
            if (dir) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {bank, maddr};
              mem_wdata <= obs_data;
            end else begin
              per_req   <= 1'b1;
              per_we    <= 1'b1;
              per_addr  <= per_a;
              per_wdata <= obs_data;
            end
          end
          if (last) begin
            idx <= idx + 2'd1;
            if (count == 16'd0) begin
              act[ch] <= 1'b0;
              if (nxt_any) begin
                ch    <= nxt_ch;
                state <= S_CHN;
              end else begin
                busy  <= 1'b0;
                state <= S_IDLE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma8_engine.sv
module dma8_engine #(
  parameter int CH_NUM = 8,
  parameter int STEP   = 8,
  parameter int CH_W   = $clog2(CH_NUM),
  parameter int RA_W   = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              start_wr,
  input  logic [CH_NUM-1:0] start_mask,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [23:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              per_req,
  output logic              per_we,
  output logic [7:0]        per_addr,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata
);
  logic [7:0]      ob;
  logic [CH_W-1:0] ch;
  logic            upd_en, obs_en;
  logic [15:0]     upd_maddr, upd_count;
  logic [7:0]      obs_data;
  logic [2:0]      s_mode;
  logic            s_fix, s_dec, s_dir;
  logic [7:0]      s_paddr, s_bank;
  logic [15:0]     s_maddr, s_count;

  always_ff @(posedge clk) begin
    if (rst)         ob <= 8'h00;
    else if (reg_wr) ob <= reg_wdata;
    else if (obs_en) ob <= obs_data;
  end

  dma8_regfile #(.CH_NUM(CH_NUM), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .rd_en(reg_rd),
    .acc_ch(reg_addr[RA_W-1:4]), .acc_off(reg_addr[3:0]),
    .wdata(reg_wdata), .ob(ob), .rdata(reg_rdata),
    .upd_en(upd_en), .upd_ch(ch), .upd_maddr(upd_maddr), .upd_count(upd_count),
    .sel_ch(ch), .sel_mode(s_mode), .sel_fix(s_fix), .sel_dec(s_dec), .sel_dir(s_dir),
    .sel_paddr(s_paddr), .sel_maddr(s_maddr), .sel_bank(s_bank), .sel_count(s_count)
  );

  dma8_seq #(.CH_NUM(CH_NUM), .CH_W(CH_W), .STEP(STEP)) u_seq (
    .clk(clk), .rst(rst),
    .start_wr(start_wr), .start_mask(start_mask),
    .mode(s_mode), .fix(s_fix), .dec(s_dec), .dir(s_dir),
    .paddr(s_paddr), .maddr(s_maddr), .bank(s_bank), .count(s_count),
    .ob(ob), .mem_rdata(mem_rdata), .per_rdata(per_rdata),
    .ch(ch), .busy(busy),
    .upd_en(upd_en), .upd_maddr(upd_maddr), .upd_count(upd_count),
    .obs_en(obs_en), .obs_data(obs_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata)
  );
endmodule

// File: rtl/dma8_checker.sv
module dma8_checker (
  input logic clk,
  input logic rst,
  input logic start_wr,
  input logic busy,
  input logic mem_req,
  input logic per_req
);
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_wr));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !per_req));

  // R8
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && per_req));

  // R12
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R12
  per_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    per_req |=> !per_req);
endmodule

bind dma8_engine dma8_checker u_dma8_checker (
  .clk(clk), .rst(rst), .start_wr(start_wr), .busy(busy),
  .mem_req(mem_req), .per_req(per_req)
);

// File: tb/test_dma8_engine.sv
module test_dma8_engine;
  localparam int STEP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        start_wr = 1'b0;
  logic [7:0]  start_mask = '0;
  logic        busy;
  logic        mem_req, mem_we, per_req, per_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, per_addr, per_wdata;
  logic [7:0]  mem_rdata = '0, per_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] ob_b = 8'h00;

  always #5 clk = ~clk;

  dma8_engine i_dma8_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_wr(start_wr),
    .start_mask(start_mask), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  function automatic logic [7:0] mfun(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pfun(input logic [7:0] a);
    return a ^ 8'hC3;
  endfunction

  // bus models and logs
  logic [23:0] mw_a[$];
  logic [7:0]  mw_d[$], pw_a[$], pw_d[$];
  int mr_n = 0, pr_n = 0;
  always @(posedge clk) begin
    if (mem_req && !mem_we) begin mem_rdata <= mfun(mem_addr); mr_n++; end
    if (mem_req && mem_we) begin mw_a.push_back(mem_addr); mw_d.push_back(mem_wdata); end
    if (per_req && !per_we) begin per_rdata <= pfun(per_addr); pr_n++; end
    if (per_req && per_we) begin pw_a.push_back(per_addr); pw_d.push_back(per_wdata); end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL R3 watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  task automatic reg_write(input int ch, input int off, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'((ch << 4) | off); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    ob_b = d;
  endtask

  task automatic reg_read(input int ch, input int off, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 7'((ch << 4) | off);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // expected-value helpers from the requirements
  function automatic logic [1:0] b_off(input logic [2:0] m, input int b);
    case (m)
      3'd1, 3'd5: return 2'(b % 2);
      3'd3, 3'd7: return 2'((b / 2) % 2);
      3'd4:       return 2'(b % 4);
      default:    return 2'd0;
    endcase
  endfunction
  function automatic logic b_low(input logic [7:0] bk);
    return (bk < 8'h40) || (bk >= 8'h80 && bk < 8'hC0);
  endfunction
  function automatic logic b_pok(input logic [7:0] pa, input logic [7:0] bk, input logic [15:0] ma);
    if (pa != 8'h80) return 1'b1;
    if (bk == 8'h7E || bk == 8'h7F) return 1'b0;
    return !(b_low(bk) && ma < 16'h2000);
  endfunction
  function automatic logic b_mok(input logic [7:0] bk, input logic [15:0] ma);
    if (!b_low(bk)) return 1'b1;
    return !(ma == 16'h420B || ma == 16'h420C || (ma >= 16'h4300 && ma <= 16'h437F) ||
             (ma >= 16'h2100 && ma <= 16'h21FF));
  endfunction

  logic [7:0]  c_ctrl[8], c_pa[8], c_bank[8];
  logic [15:0] c_ma[8], c_cnt[8];

  task automatic program_ch(input int i);
    reg_write(i, 0, c_ctrl[i]);
    reg_write(i, 1, c_pa[i]);
    reg_write(i, 2, c_ma[i][7:0]);
    reg_write(i, 3, c_ma[i][15:8]);
    reg_write(i, 4, c_bank[i]);
    reg_write(i, 5, c_cnt[i][7:0]);
    reg_write(i, 6, c_cnt[i][15:8]);
  endtask

  task automatic run_xfer(input logic [7:0] mask, input int inj_at, input logic [7:0] inj_mask);
    logic [23:0] em_a[$];
    logic [7:0]  em_d[$], ep_a[$], ep_d[$];
    logic [15:0] fin_ma[8];
    int emr = 0, epr = 0, exp_busy = 2 * STEP, cyc;
    logic [7:0] obm = ob_b, d, rb_lo, rb_hi;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ma = c_ma[i];
      if (!mask[i]) continue;
      exp_busy += STEP * (1 + int'(c_cnt[i]));
      for (int b = 0; b < int'(c_cnt[i]); b++) begin
        logic [7:0] pa = c_pa[i] + 8'(b_off(c_ctrl[i][2:0], b));
        logic pk = b_pok(pa, c_bank[i], ma);
        logic mk = b_mok(c_bank[i], ma);
        if (c_ctrl[i][7]) begin
          d = pk ? pfun(pa) : obm;
          if (pk) epr++;
          if (mk) begin em_a.push_back({c_bank[i], ma}); em_d.push_back(d); end
        end else begin
          d = mk ? mfun({c_bank[i], ma}) : obm;
          if (mk) emr++;
          if (pk) begin ep_a.push_back(pa); ep_d.push_back(d); end
        end
        obm = d;
        if (!c_ctrl[i][3]) ma = c_ctrl[i][4] ? ma - 16'd1 : ma + 16'd1;
      end
      fin_ma[i] = ma;
    end
    mw_a.delete(); mw_d.delete(); pw_a.delete(); pw_d.delete();
    mr_n = 0; pr_n = 0;
    @(negedge clk);
    start_wr = 1'b1; start_mask = mask;
    @(negedge clk);
    start_wr = 1'b0;
    chk(busy === 1'b1, "R3 busy after start", int'(busy), 1);
    cyc = 0;
    while (busy === 1'b1 && cyc < 100000) begin
      cyc++;
      if (cyc == inj_at) begin start_wr = 1'b1; start_mask = inj_mask; end
      else start_wr = 1'b0;
      @(negedge clk);
    end
    start_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R3 no restart", int'(busy), 0);
    chk(cyc == exp_busy, "R4 busy length", cyc, exp_busy);
    chk(mw_a.size() == em_a.size(), "R11 mem write count", mw_a.size(), em_a.size());
    chk(pw_a.size() == ep_a.size(), "R11 per write count", pw_a.size(), ep_a.size());
    chk(mr_n == emr, "R10 mem read count", mr_n, emr);
    chk(pr_n == epr, "R9 per read count", pr_n, epr);
    if (mw_a.size() == em_a.size())
      for (int k = 0; k < em_a.size(); k++) begin
        chk(mw_a[k] == em_a[k], "R6 mem write addr", int'(mw_a[k]), int'(em_a[k]));
        chk(mw_d[k] == em_d[k], "R8 mem write data", int'(mw_d[k]), int'(em_d[k]));
      end
    if (pw_a.size() == ep_a.size())
      for (int k = 0; k < ep_a.size(); k++) begin
        chk(pw_a[k] == ep_a[k], "R5 per write addr", int'(pw_a[k]), int'(ep_a[k]));
        chk(pw_d[k] == ep_d[k], "R8 per write data", int'(pw_d[k]), int'(ep_d[k]));
      end
    ob_b = obm;
    for (int i = 0; i < 8; i++) begin
      if (!mask[i]) continue;
      reg_read(i, 2, rb_lo); reg_read(i, 3, rb_hi);
      chk({rb_hi, rb_lo} == fin_ma[i], "R6 final offset", int'({rb_hi, rb_lo}), int'(fin_ma[i]));
      reg_read(i, 5, rb_lo); reg_read(i, 6, rb_hi);
      chk({rb_hi, rb_lo} == 16'h0, "R7 final count", int'({rb_hi, rb_lo}), 0);
    end
    // open bus now reflects the last moved byte (reads do not change it)
    reg_read(0, 12, rb_lo);
    chk(rb_lo == ob_b, "R2 open bus after run", int'(rb_lo), int'(ob_b));
  endtask

  initial begin
    logic [7:0] v, v2;
    logic [7:0] banks[7] = '{8'h00, 8'h7E, 8'h7F, 8'h80, 8'h40, 8'hC0, 8'h12};
    logic [15:0] offs[6] = '{16'h1FFE, 16'h420A, 16'h42FF, 16'h2100, 16'h8000, 16'h0001};
    logic [7:0] pas[4] = '{8'h7F, 8'h80, 8'h7E, 8'h20};
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(busy === 1'b0, "R12 reset busy", int'(busy), 0);
    reg_read(0, 0, v);  chk(v == 8'h00, "R1 reset ctrl", int'(v), 0);
    reg_read(7, 5, v);  chk(v == 8'h00, "R1 reset count", int'(v), 0);
    reg_read(2, 13, v); chk(v == 8'h00, "R2 reset open bus", int'(v), 0);

    // register window
    reg_write(3, 0, 8'hA5); reg_write(3, 9, 8'h3C); reg_write(3, 10, 8'h44);
    reg_write(3, 2, 8'h11); reg_write(3, 3, 8'h22); reg_write(3, 2, 8'h99);
    reg_write(3, 11, 8'h6D);
    reg_read(3, 0, v);  chk(v == 8'hA5, "R1 ctrl readback", int'(v), 'hA5);
    reg_read(3, 9, v);  chk(v == 8'h3C, "R1 table hi", int'(v), 'h3C);
    reg_read(3, 10, v); chk(v == 8'h44, "R1 line counter", int'(v), 'h44);
    reg_read(3, 3, v);  chk(v == 8'h22, "R1 high byte kept", int'(v), 'h22);
    reg_read(3, 2, v);  chk(v == 8'h99, "R1 low byte", int'(v), 'h99);
    reg_read(3, 15, v); chk(v == 8'h6D, "R1 spare alias", int'(v), 'h6D);
    reg_write(3, 15, 8'h5E);
    reg_read(3, 11, v); chk(v == 8'h5E, "R1 spare alias back", int'(v), 'h5E);
    reg_read(4, 0, v);  chk(v == 8'h00, "R1 channel decode", int'(v), 0);
    reg_write(3, 12, 8'h77);
    reg_read(3, 0, v);  chk(v == 8'hA5, "R2 unmapped write ignored", int'(v), 'hA5);
    reg_write(3, 1, 8'h21);
    reg_read(3, 13, v); chk(v == 8'h21, "R2 unmapped reads open bus", int'(v), 'h21);

    // zero mask does nothing
    @(negedge clk); start_wr = 1'b1; start_mask = 8'h00;
    @(negedge clk); start_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R3 zero mask", int'(busy), 0);

    // mode 4 pattern, mem to per, plus mode 3 channel (order ch1 then ch5)
    c_ctrl[1] = 8'h04; c_pa[1] = 8'h18; c_bank[1] = 8'h12; c_ma[1] = 16'h8000; c_cnt[1] = 16'd8;
    c_ctrl[5] = 8'h03; c_pa[5] = 8'h30; c_bank[5] = 8'hC1; c_ma[5] = 16'h1000; c_cnt[5] = 16'd5;
    program_ch(1); program_ch(5);
    run_xfer(8'h22, 0, 8'h00);

    // decrement wraps, per to mem; start pulse mid-run ignored (R3)
    c_ctrl[2] = 8'h91; c_pa[2] = 8'h40; c_bank[2] = 8'h7E; c_ma[2] = 16'h0001; c_cnt[2] = 16'd3;
    program_ch(2);
    run_xfer(8'h04, 20, 8'h01);

    // forbidden peripheral read (R9): addr 0x80 with bank 0x7F, per to mem
    reg_write(6, 10, 8'hE7);
    c_ctrl[6] = 8'h80; c_pa[6] = 8'h80; c_bank[6] = 8'h7F; c_ma[6] = 16'h0100; c_cnt[6] = 16'd2;
    program_ch(6);
    run_xfer(8'h40, 0, 8'h00);

    // forbidden memory read (R10) fixed at 0x420B; forbidden memory write at 0x2100
    c_ctrl[0] = 8'h08; c_pa[0] = 8'h10; c_bank[0] = 8'h00; c_ma[0] = 16'h420B; c_cnt[0] = 16'd2;
    c_ctrl[7] = 8'h88; c_pa[7] = 8'h11; c_bank[7] = 8'h80; c_ma[7] = 16'h2100; c_cnt[7] = 16'd2;
    program_ch(0); program_ch(7);
    run_xfer(8'h81, 0, 8'h00);

    // random mixes
    for (int it = 0; it < 8; it++) begin
      logic [7:0] m = 8'($urandom_range(1, 255)) & 8'($urandom_range(1, 255));
      if (m == 0) m = 8'h08;
      for (int i = 0; i < 8; i++) begin
        c_ctrl[i] = 8'($urandom()) & 8'hBF;
        c_pa[i]   = pas[$urandom_range(0, 3)];
        c_bank[i] = banks[$urandom_range(0, 6)];
        c_ma[i]   = offs[$urandom_range(0, 5)];
        c_cnt[i]  = 16'($urandom_range(1, 5));
        if (m[i]) program_ch(i);
      end
      run_xfer(m, 0, 8'h00);
    end

    // count zero means 65536 bytes (R7)
    c_ctrl[0] = 8'h00; c_pa[0] = 8'h01; c_bank[0] = 8'h20; c_ma[0] = 16'h9000; c_cnt[0] = 16'd0;
    program_ch(0);
    @(negedge clk); start_wr = 1'b1; start_mask = 8'h01;
    @(negedge clk); start_wr = 1'b0;
    repeat (40) @(negedge clk);
    reg_read(0, 5, v); reg_read(0, 6, v2);
    chk(v == 8'hFE, "R7 zero count low", int'(v), 'hFE);
    chk(v2 == 8'hFF, "R7 zero count high", int'(v2), 'hFF);
    chk(busy === 1'b1, "R7 still running", int'(busy), 1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R12 reset ends run", int'(busy), 0);

    summary();
    $finish;
  end
endmodule